// File: doc/BRIEF.md
# Scaling Step Generator for One Video Axis

The block works out the fixed-point step that a video scaler needs along one axis, horizontal or vertical, and then walks that step across an output line. A start pulse captures a source size and a destination size. The block chooses a coarse pre-divider: none, halve or quarter. It then divides the pre-divided source size, raised to 21 fractional bits, by the destination size, always rounding the quotient up. From this master step it forms the shifted copies that the luma and chroma step registers of either axis expect.

Once the step is ready, a digital differential analyser starts at zero on each line-start pulse and adds the master step once for every output-pixel strobe. The integer part of the accumulator is the source sample index. Its top four fractional bits are the phase for a downstream interpolation filter. A zero size is refused: the block flags a configuration error and keeps the analyser parked at position zero.

Top module: `scale_step_gen`

## Requirements
- R1: On an accepted start the pre-divider `div_sel_o` is 2'b00 (none) when src <= dst, 2'b01 (halve) when dst < src <= 2*dst, and 2'b10 (quarter) when src > 2*dst. The effective source is src, src>>1 or src>>2 respectively. The code 2'b11 never appears.
- R2: `master_step_o` equals ceil(effective_src * 2^21 / dst), computed exactly and rounded up whenever the remainder is non-zero.
- R3: `step_luma_o` equals master>>2 and `step_aux_o` equals master>>1, whatever the divider.
- R4: When the divider is none, `step_vc_a_o` = master>>2 and `step_vc_b_o` = master>>1. When the divider is halve or quarter, `step_vc_a_o` = master>>3 and `step_vc_b_o` = master.
- R5: A start with src = 0 or dst = 0 sets `cfg_error_o`, clears `step_ok_o`, starts no division (`busy_o` stays low), and holds `src_index_o`/`src_phase_o` at 0 through any strobes or line starts. The next valid start clears `cfg_error_o`.
- R6: A valid start raises `busy_o` in the following cycle, with `step_ok_o` low. `done_o` is a one-cycle pulse that ends the division. `step_ok_o` rises and the new step values appear in the cycle after `done_o`. A start while `busy_o` is high is ignored.
- R7: With `step_ok_o` high, `line_start_i` returns the position to index 0, phase 0 in the next cycle.
- R8: With `step_ok_o` high, each `pix_strobe_i` adds the master step to a 37-bit accumulator. `src_index_o` is accumulator bits [36:21] and `src_phase_o` is bits [20:17]. Without a strobe, line start or start, the position holds.
- R9: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture sizes and begin computing a step |
| cfg_src_i | input | 16 | Source size in samples |
| cfg_dst_i | input | 16 | Destination size in samples |
| line_start_i | input | 1 | Restart the position at zero |
| pix_strobe_i | input | 1 | Advance one output pixel |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle pulse at division end |
| cfg_error_o | output | 1 | Last start carried a zero size |
| step_ok_o | output | 1 | Step valid, position generator active |
| div_sel_o | output | 2 | Pre-divider code |
| master_step_o | output | 37 | Master step, 21 fractional bits |
| step_luma_o | output | 37 | Luma step (master>>2) |
| step_aux_o | output | 37 | Auxiliary step (master>>1) |
| step_vc_a_o | output | 37 | Vertical chroma step A |
| step_vc_b_o | output | 37 | Vertical chroma step B |
| src_index_o | output | 16 | Integer source position |
| src_phase_o | output | 4 | Filter phase |

## Verification
A wrong quotient bit or a missing round-up shows on `master_step_o` and all its derived copies in the cycle after `done_o`. An error of a single unit only becomes visible at the index after enough strobes have added it up, so exact ratios and long lines are both checked. A wrong divider choice shows at once as the wrong code and a step off by a power of two at the boundary ratios. A stuck busy or a lost done never sets `step_ok_o`, and a broken zero-size guard lets the index move on strobes that should be ignored.

// File: rtl/scale_pkg.sv
package scale_pkg;
    typedef enum logic [1:0] {
        DIV_NONE = 2'b00,
        DIV_TWO  = 2'b01,
        DIV_FOUR = 2'b10
    } div_sel_e;
endpackage

// File: rtl/scale_prescale.sv
module scale_prescale
    import scale_pkg::*;
#(
    parameter int SIZE_W = 16
) (
    input  logic [SIZE_W-1:0] src_i,
    input  logic [SIZE_W-1:0] dst_i,
    output logic              err_o,
    output div_sel_e          sel_o,
    output logic [SIZE_W-1:0] eff_o
);
    logic [SIZE_W:0] src_x;
    logic [SIZE_W:0] dst_x2;

    always_comb begin
        src_x  = {1'b0, src_i};
        dst_x2 = {dst_i, 1'b0};
        err_o  = (src_i == '0) || (dst_i == '0);
        if (src_i <= dst_i) begin
            sel_o = DIV_NONE;
            eff_o = src_i;
        end else if (src_x <= dst_x2) begin
            sel_o = DIV_TWO;
            eff_o = src_i >> 1;
        end else begin
            sel_o = DIV_FOUR;
            eff_o = src_i >> 2;
        end
    end
endmodule

// File: rtl/scale_divider.sv
module scale_divider #(
    parameter int SIZE_W = 16,
    parameter int FRAC_W = 21,
    localparam int NUM_W = SIZE_W + FRAC_W,
    localparam int CNT_W = $clog2(NUM_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [SIZE_W-1:0] num_i,
    input  logic [SIZE_W-1:0] den_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [NUM_W-1:0]  quot_o
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CNT_W-1:0]  cnt;
        logic [NUM_W-1:0]  work;
        logic [SIZE_W-1:0] rem;
        logic [SIZE_W-1:0] den;
        logic [NUM_W-1:0]  quot;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [SIZE_W:0]   trial;
    logic              qbit;
    logic [NUM_W-1:0]  work_nx;
    logic [SIZE_W-1:0] rem_nx;

    always_comb begin
        st_d    = st_q;
        st_d.done = 1'b0;
        trial   = {st_q.rem, st_q.work[NUM_W-1]};
        qbit    = (trial >= {1'b0, st_q.den});
        rem_nx  = qbit ? SIZE_W'(trial - {1'b0, st_q.den}) : trial[SIZE_W-1:0];
        work_nx = {st_q.work[NUM_W-2:0], qbit};
        if (st_q.busy) begin
            st_d.work = work_nx;
            st_d.rem  = rem_nx;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(NUM_W - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.quot = work_nx + NUM_W'(rem_nx != '0);
            end
        end else if (go_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.work = {num_i, {FRAC_W{1'b0}}};
            st_d.rem  = '0;
            st_d.den  = den_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign quot_o = st_q.quot;
endmodule

// File: rtl/scale_dda.sv
module scale_dda #(
    parameter int SIZE_W  = 16,
    parameter int FRAC_W  = 21,
    parameter int PHASE_W = 4,
    localparam int ACC_W  = SIZE_W + FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               adv_i,
    input  logic [ACC_W-1:0]   step_i,
    output logic [SIZE_W-1:0]  index_o,
    output logic [PHASE_W-1:0] phase_o
);
    logic [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr_i)      acc_d = '0;
        else if (adv_i) acc_d = acc_q + step_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign index_o = acc_q[ACC_W-1:FRAC_W];
    assign phase_o = acc_q[FRAC_W-1 -: PHASE_W];
endmodule

// File: rtl/scale_step_gen.sv
module scale_step_gen
    import scale_pkg::*;
#(
    parameter int SIZE_W  = 16,
    parameter int FRAC_W  = 21,
    parameter int PHASE_W = 4,
    localparam int STEP_W = SIZE_W + FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [SIZE_W-1:0]  cfg_src_i,
    input  logic [SIZE_W-1:0]  cfg_dst_i,
    input  logic               line_start_i,
    input  logic               pix_strobe_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               cfg_error_o,
    output logic               step_ok_o,
    output logic [1:0]         div_sel_o,
    output logic [STEP_W-1:0]  master_step_o,
    output logic [STEP_W-1:0]  step_luma_o,
    output logic [STEP_W-1:0]  step_aux_o,
    output logic [STEP_W-1:0]  step_vc_a_o,
    output logic [STEP_W-1:0]  step_vc_b_o,
    output logic [SIZE_W-1:0]  src_index_o,
    output logic [PHASE_W-1:0] src_phase_o
);
    typedef struct packed {
        logic              err;
        logic              ok;
        div_sel_e          sel;
        logic [STEP_W-1:0] master;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              pre_err;
    div_sel_e          pre_sel;
    logic [SIZE_W-1:0] pre_eff;
    logic              div_busy;
    logic              div_done;
    logic [STEP_W-1:0] div_quot;
    logic              launch;
    logic              dda_clr;
    logic              dda_adv;
    logic              enlarge;

    scale_prescale #(.SIZE_W(SIZE_W)) u_pre (
        .src_i (cfg_src_i),
        .dst_i (cfg_dst_i),
        .err_o (pre_err),
        .sel_o (pre_sel),
        .eff_o (pre_eff)
    );

    assign launch = start_i && !div_busy && !pre_err;

    scale_divider #(.SIZE_W(SIZE_W), .FRAC_W(FRAC_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (launch),
        .num_i  (pre_eff),
        .den_i  (cfg_dst_i),
        .busy_o (div_busy),
        .done_o (div_done),
        .quot_o (div_quot)
    );

    always_comb begin
        st_d = st_q;
        if (div_done) begin
            st_d.master = div_quot;
            st_d.ok     = 1'b1;
        end
        if (start_i && !div_busy) begin
            st_d.ok = 1'b0;
            if (pre_err) begin
                st_d.err = 1'b1;
            end else begin
                st_d.err = 1'b0;
                st_d.sel = pre_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dda_clr = (start_i && !div_busy) || (line_start_i && st_q.ok);
    assign dda_adv = pix_strobe_i && st_q.ok;

    scale_dda #(.SIZE_W(SIZE_W), .FRAC_W(FRAC_W), .PHASE_W(PHASE_W)) u_dda (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (dda_clr),
        .adv_i   (dda_adv),
        .step_i  (st_q.master),
        .index_o (src_index_o),
        .phase_o (src_phase_o)
    );

    assign enlarge       = (st_q.sel == DIV_NONE);
    assign busy_o        = div_busy;
    assign done_o        = div_done;
    assign cfg_error_o   = st_q.err;
    assign step_ok_o     = st_q.ok;
    assign div_sel_o     = st_q.sel;
    assign master_step_o = st_q.master;
    assign step_luma_o   = st_q.master >> 2;
    assign step_aux_o    = st_q.master >> 1;
    assign step_vc_a_o   = enlarge ? (st_q.master >> 2) : (st_q.master >> 3);
    assign step_vc_b_o   = enlarge ? (st_q.master >> 1) : st_q.master;
endmodule

module scale_step_gen_chk #(
    parameter int SIZE_W  = 16,
    parameter int FRAC_W  = 21,
    parameter int PHASE_W = 4,
    localparam int STEP_W = SIZE_W + FRAC_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               line_start_i,
    input logic               pix_strobe_i,
    input logic               busy_o,
    input logic               done_o,
    input logic               cfg_error_o,
    input logic               step_ok_o,
    input logic [1:0]         div_sel_o,
    input logic [STEP_W-1:0]  master_step_o,
    input logic [SIZE_W-1:0]  src_index_o,
    input logic [PHASE_W-1:0] src_phase_o
);
    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        div_sel_o != 2'b11);

    a_r5_error_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error_o |-> (!step_ok_o && !busy_o));

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_done_then_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> step_ok_o);

    a_r6_busy_not_ok: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !step_ok_o);

    a_r7_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok_o && line_start_i) |=> (src_index_o == '0 && src_phase_o == '0));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_strobe_i && !line_start_i && !start_i) |=>
            ($stable(src_index_o) && $stable(src_phase_o)));

    a_r8_step_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok_o && !start_i) |=> $stable(master_step_o));
endmodule

bind scale_step_gen scale_step_gen_chk #(
    .SIZE_W(SIZE_W), .FRAC_W(FRAC_W), .PHASE_W(PHASE_W)
) u_chk (.*);

// File: tb/scale_step_gen_test.sv
module scale_step_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] cfg_src_i = '0;
    logic [15:0] cfg_dst_i = '0;
    logic        line_start_i = 1'b0;
    logic        pix_strobe_i = 1'b0;
    logic        busy_o, done_o, cfg_error_o, step_ok_o;
    logic [1:0]  div_sel_o;
    logic [36:0] master_step_o, step_luma_o, step_aux_o, step_vc_a_o, step_vc_b_o;
    logic [15:0] src_index_o;
    logic [3:0]  src_phase_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    scale_step_gen uut (.*);

    localparam int NV = 10;
    localparam logic [15:0] V_SRC [NV] = '{16'd100, 16'd360, 16'd720, 16'd720, 16'd1,
                                           16'd65535, 16'd3, 16'd1000, 16'd2000, 16'd2001};
    localparam logic [15:0] V_DST [NV] = '{16'd100, 16'd720, 16'd360, 16'd200, 16'd3,
                                           16'd1, 16'd1, 16'd1000, 16'd1000, 16'd1000};
    localparam logic [1:0]  V_DIV [NV] = '{2'b00, 2'b00, 2'b01, 2'b10, 2'b00,
                                           2'b10, 2'b10, 2'b00, 2'b01, 2'b10};

    function automatic logic [36:0] exp_master(input logic [15:0] s, input logic [15:0] d);
        longint unsigned eff, num;
        if (s <= d)                         eff = s;
        else if (32'(s) <= 32'(d) * 2)      eff = s >> 1;
        else                                eff = s >> 2;
        num = eff << 21;
        return 37'((num + d - 1) / d);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_start(input logic [15:0] s, input logic [15:0] d);
        cfg_src_i = s;
        cfg_dst_i = d;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 200) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic strobe(input int k);
        for (int i = 0; i < k; i++) begin
            pix_strobe_i = 1'b1;
            @(negedge clk);
            pix_strobe_i = 1'b0;
        end
    endtask

    task automatic line();
        line_start_i = 1'b1;
        @(negedge clk);
        line_start_i = 1'b0;
    endtask

    task automatic check_pos(input string tag, input logic [36:0] m, input int k);
        logic [36:0] acc;
        acc = 37'(m * k);
        check({tag, " index"}, src_index_o, acc[36:21]);
        check({tag, " phase"}, src_phase_o, acc[20:17]);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        logic [36:0] m;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 busy", busy_o, 0);
        check("R9 step_ok", step_ok_o, 0);
        check("R9 error", cfg_error_o, 0);
        check("R9 master", master_step_o, 0);
        check("R9 index", src_index_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            m = exp_master(V_SRC[v], V_DST[v]);
            do_start(V_SRC[v], V_DST[v]);
            check("R6 busy after start", busy_o, 1);
            check("R6 ok low while busy", step_ok_o, 0);
            wait_done();
            check("R6 done one cycle", done_o, 0);
            check("R6 step_ok", step_ok_o, 1);
            check("R5 no error", cfg_error_o, 0);
            check("R1 divider", div_sel_o, V_DIV[v]);
            check("R2 master", master_step_o, m);
            check("R3 luma", step_luma_o, m >> 2);
            check("R3 aux", step_aux_o, m >> 1);
            check("R4 vc_a", step_vc_a_o, (V_DIV[v] == 2'b00) ? (m >> 2) : (m >> 3));
            check("R4 vc_b", step_vc_b_o, (V_DIV[v] == 2'b00) ? (m >> 1) : m);
        end

        // R8 position walk for an exact 0.75 step
        do_start(16'd3, 16'd4);
        wait_done();
        m = exp_master(16'd3, 16'd4);
        line();
        check_pos("R7 cleared", m, 0);
        for (int k = 1; k <= 5; k++) begin
            strobe(1);
            check_pos("R8 walk 3/4", m, k);
        end
        repeat (4) @(negedge clk);
        check_pos("R8 hold idle", m, 5);
        line();
        check_pos("R7 line restart", m, 0);

        // R8 rounded-up step accumulated over a line
        do_start(16'd1, 16'd3);
        wait_done();
        m = exp_master(16'd1, 16'd3);
        line();
        strobe(7);
        check_pos("R8 walk 1/3", m, 7);
        strobe(293);
        check_pos("R8 long 1/3", m, 300);

        // R6 start while busy is ignored
        do_start(16'd720, 16'd360);
        do_start(16'd1, 16'd3);
        wait_done();
        check("R6 ignored start div", div_sel_o, 2'b01);
        check("R6 ignored start master", master_step_o, 37'd2097152);
        line();
        strobe(40);
        check_pos("R8 unit step", 37'd2097152, 40);

        // R5 zero sizes
        do_start(16'd0, 16'd100);
        check("R5 error set", cfg_error_o, 1);
        check("R5 ok low", step_ok_o, 0);
        check("R5 no busy", busy_o, 0);
        check("R5 index parked", src_index_o, 0);
        strobe(3);
        line();
        strobe(2);
        check("R5 index frozen", src_index_o, 0);
        check("R5 phase frozen", src_phase_o, 0);
        do_start(16'd100, 16'd0);
        check("R5 dst zero error", cfg_error_o, 1);
        check("R5 dst zero no busy", busy_o, 0);
        do_start(16'd3, 16'd4);
        check("R5 error cleared", cfg_error_o, 0);
        wait_done();
        check("R5 recovered ok", step_ok_o, 1);
        check("R2 recovered master", master_step_o, 37'd1572864);

        summary();
    end
endmodule